// File: doc/BRIEF.md
# Parallel Base-Delta Line Compressor

This block compresses one 32-byte cache line at a time. Every candidate encoding is tried at once: six base-plus-delta units with different element and delta widths, a detector for an all-zero line and a detector for a line made of one repeated 8-byte word. Each base-plus-delta unit takes the line's first element as its stored base and also allows a second base of zero that is never written into the payload. A per-element mask bit records which of the two bases each delta refers to.

A selector then takes, among the units that succeed, the one whose compressed size is smallest, and the result is registered. A line that no unit can encode leaves the block tagged as raw, with the line copied unchanged into the payload. The block accepts one line per clock with a single valid strobe and delivers each result exactly two clocks later, in the order the lines arrived. Placing lines in a cache and expanding them again are handled elsewhere.

Elements are little-endian: element i of width W bytes occupies line bits [i*W*8 +: W*8].

Top module: `bdz_compressor`

## Requirements
- R1: When inValid is high at a rising edge, outValid is high for exactly one cycle after the second rising edge that follows, carrying that line's result. With no new result the output fields keep their last values.
- R2: An all-zero line gives tag 0, size 1, an all-zero payload and an all-zero mask.
- R3: A non-zero line whose four 8-byte words are all equal gives tag 1 and size 8, with that word in payload bytes 0..7 and zeros above.
- R4: A base-delta encoding (tag: base bytes/delta bytes = 2: 8/1, 3: 8/2, 4: 8/4, 5: 4/1, 6: 4/2, 7: 2/1) succeeds only when every element, minus the first element, modulo 2^(8*base bytes), fits as a two's-complement value of the delta width, or the element itself fits that way; the limits +2^(8D-1)-1 and -2^(8D-1) fit and one beyond does not.
- R5: Mask bit i is 1 when element i is encoded against the implicit zero base and 0 when it uses the stored base; the stored base is chosen when both fit. Tags 0, 1 and 8 give a zero mask, and mask bits at or above the element count are zero.
- R6: The size of a base-delta encoding is base bytes plus (32 / base bytes) times delta bytes; zero costs 1 byte, repeated word 8 bytes, raw 32 bytes.
- R7: Among successful encodings the smallest size wins; on equal size the lower tag wins (8/1 beats 4/1 at 12 bytes).
- R8: When no encoding succeeds, the tag is 8, the size 32, the payload equals the input line, the mask is zero and outCompressed is 0; outCompressed is 1 for every other tag.
- R9: During and right after reset outValid, outCompressed, outTag, outSize, outPayload and outMask are all zero.
- R10: Lines presented on consecutive cycles each yield their own result on consecutive cycles, in arrival order.
- R11: A base-delta payload holds the base in bytes 0..B-1 and the delta of element i in bytes B+i*D..B+i*D+D-1 (the difference for stored-base elements, the low bytes of the element itself for zero-base elements), with all higher bytes zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | A line is presented this cycle |
| inLine | input | 256 | Uncompressed line, element 0 in the low bits |
| outValid | output | 1 | Result valid this cycle |
| outCompressed | output | 1 | 1 when the tag is not raw |
| outTag | output | 4 | Selected encoding code 0..8 |
| outSize | output | 6 | Compressed size in bytes |
| outPayload | output | 256 | Compressed bytes, packed from byte 0 |
| outMask | output | 16 | Per-element base select, 1 = zero base |

## Verification
Two things can land in one cycle: the capture of a new line and the commit of the line before it, and, inside a single line, several encodings succeeding together so that the selector must arbitrate between them. The first is provoked by a burst of lines with no idle cycles, judged by the scoreboard's arrival order and a cycle stamp that must show a delay of exactly two. The second is provoked by lines built to satisfy several units at once (zero lines that every unit accepts, a repeated word, small deltas that fit both 8/1 and 4/1 at the same size), judged against hand-chosen tags and a reference model written independently inside the bench.

// File: rtl/bdz_pkg.sv
package bdz_pkg;
  localparam int LINE_BYTES = 32;
  localparam int LINE_BITS  = LINE_BYTES * 8;
  localparam int ENC_COUNT  = 8;
  localparam int ENC_IDX_W  = $clog2(ENC_COUNT);
  localparam int TAG_W      = ENC_IDX_W + 1;
  localparam int TAG_RAW    = ENC_COUNT;
  localparam int REP_BYTES  = 8;
  localparam int MASK_W     = LINE_BYTES / 2;
  localparam int SIZE_W     = $clog2(LINE_BYTES) + 1;
  localparam int ZERO_COST  = 1;

  typedef struct packed {
    logic capture;
    logic commit;
  } strobe_t;

  function automatic int encBase(input int t);
    case (t)
      2, 3, 4: return 8;
      5, 6:    return 4;
      7:       return 2;
      default: return 0;
    endcase
  endfunction

  function automatic int encDelta(input int t);
    case (t)
      2, 5, 7: return 1;
      3, 6:    return 2;
      4:       return 4;
      default: return 0;
    endcase
  endfunction

  function automatic int encSize(input int t);
    if (t == 0)       return ZERO_COST;
    if (t == 1)       return REP_BYTES;
    if (t >= TAG_RAW) return LINE_BYTES;
    return encBase(t) + (LINE_BYTES / encBase(t)) * encDelta(t);
  endfunction
endpackage

// File: rtl/bdz_unit.sv
module bdz_unit
  import bdz_pkg::*;
#(
  parameter int BASE_BYTES  = 8,
  parameter int DELTA_BYTES = 1
) (
  input  logic [LINE_BITS-1:0] line,
  output logic                 ok,
  output logic [LINE_BITS-1:0] payload,
  output logic [MASK_W-1:0]    mask
);
  localparam int W = BASE_BYTES * 8;
  localparam int D = DELTA_BYTES * 8;
  localparam int N = LINE_BYTES / BASE_BYTES;

  function automatic logic fitsDelta(input logic [W-1:0] v);
    return (&v[W-1:D-1]) || !(|v[W-1:D-1]);
  endfunction

  logic [W-1:0] base;
  logic [W-1:0] elem;
  logic [W-1:0] diff;

  always_comb begin
    base    = line[W-1:0];
    ok      = 1'b1;
    payload = '0;
    mask    = '0;
    elem    = '0;
    diff    = '0;
    payload[W-1:0] = base;
    for (int i = 0; i < N; i++) begin
      elem = line[i*W +: W];
      diff = elem - base;
      if (fitsDelta(diff)) begin
        payload[W + i*D +: D] = diff[D-1:0];
      end else if (fitsDelta(elem)) begin
        payload[W + i*D +: D] = elem[D-1:0];
        mask[i] = 1'b1;
      end else begin
        ok = 1'b0;
      end
    end
  end
endmodule

// File: rtl/bdz_select.sv
module bdz_select
  import bdz_pkg::*;
(
  input  logic [ENC_COUNT-1:0] unitOk,
  output logic [TAG_W-1:0]     selTag,
  output logic [SIZE_W-1:0]    selSize
);
  always_comb begin
    selTag  = TAG_W'(TAG_RAW);
    selSize = SIZE_W'(LINE_BYTES);
    for (int t = 0; t < ENC_COUNT; t++) begin
      if (unitOk[t] && (SIZE_W'(encSize(t)) < selSize)) begin
        selTag  = TAG_W'(t);
        selSize = SIZE_W'(encSize(t));
      end
    end
  end
endmodule

// File: rtl/bdz_ctrl.sv
module bdz_ctrl
  import bdz_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    inValid,
  output strobe_t stb,
  output logic    outValid
);
  logic vldS1;
  logic vldS2;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      vldS1 <= 1'b0;
      vldS2 <= 1'b0;
    end else begin
      vldS1 <= inValid;
      vldS2 <= vldS1;
    end
  end

  assign stb.capture = inValid;
  assign stb.commit  = vldS1;
  assign outValid    = vldS2;
endmodule

// File: rtl/bdz_datapath.sv
module bdz_datapath
  import bdz_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  strobe_t              stb,
  input  logic [LINE_BITS-1:0] inLine,
  output logic                 compFlag,
  output logic [TAG_W-1:0]     tagQ,
  output logic [SIZE_W-1:0]    sizeQ,
  output logic [LINE_BITS-1:0] payloadQ,
  output logic [MASK_W-1:0]    maskQ
);
  localparam int REP_BITS  = REP_BYTES * 8;
  localparam int REP_WORDS = LINE_BYTES / REP_BYTES;

  logic [LINE_BITS-1:0] lineQ;
  logic [ENC_COUNT-1:0] unitOk;
  logic [LINE_BITS-1:0] unitPayload [ENC_COUNT];
  logic [MASK_W-1:0]    unitMask    [ENC_COUNT];
  logic [TAG_W-1:0]     selTag;
  logic [SIZE_W-1:0]    selSize;
  logic                 isRep;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            lineQ <= '0;
    else if (stb.capture) lineQ <= inLine;
  end

  always_comb begin
    isRep = 1'b1;
    for (int w = 1; w < REP_WORDS; w++) begin
      if (lineQ[w*REP_BITS +: REP_BITS] != lineQ[REP_BITS-1:0]) isRep = 1'b0;
    end
  end

  assign unitOk[0]      = ~|lineQ;
  assign unitPayload[0] = '0;
  assign unitMask[0]    = '0;
  assign unitOk[1]      = isRep;
  assign unitPayload[1] = {{(LINE_BITS-REP_BITS){1'b0}}, lineQ[REP_BITS-1:0]};
  assign unitMask[1]    = '0;

  for (genvar g = 2; g < ENC_COUNT; g++) begin : g_unit
    bdz_unit #(
      .BASE_BYTES (encBase(g)),
      .DELTA_BYTES(encDelta(g))
    ) u_unit (
      .line   (lineQ),
      .ok     (unitOk[g]),
      .payload(unitPayload[g]),
      .mask   (unitMask[g])
    );
  end

  bdz_select u_sel (
    .unitOk (unitOk),
    .selTag (selTag),
    .selSize(selSize)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      compFlag <= 1'b0;
      tagQ     <= '0;
      sizeQ    <= '0;
      payloadQ <= '0;
      maskQ    <= '0;
    end else if (stb.commit) begin
      tagQ  <= selTag;
      sizeQ <= selSize;
      if (selTag[ENC_IDX_W]) begin
        compFlag <= 1'b0;
        payloadQ <= lineQ;
        maskQ    <= '0;
      end else begin
        compFlag <= 1'b1;
        payloadQ <= unitPayload[selTag[ENC_IDX_W-1:0]];
        maskQ    <= unitMask[selTag[ENC_IDX_W-1:0]];
      end
    end
  end
endmodule

// File: rtl/bdz_compressor.sv
module bdz_compressor
  import bdz_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 inValid,
  input  logic [LINE_BITS-1:0] inLine,
  output logic                 outValid,
  output logic                 outCompressed,
  output logic [TAG_W-1:0]     outTag,
  output logic [SIZE_W-1:0]    outSize,
  output logic [LINE_BITS-1:0] outPayload,
  output logic [MASK_W-1:0]    outMask
);
  strobe_t stb;

  bdz_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .inValid (inValid),
    .stb     (stb),
    .outValid(outValid)
  );

  bdz_datapath u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .stb     (stb),
    .inLine  (inLine),
    .compFlag(outCompressed),
    .tagQ    (outTag),
    .sizeQ   (outSize),
    .payloadQ(outPayload),
    .maskQ   (outMask)
  );
endmodule

// File: rtl/bdz_compressor_chk.sv
module bdz_compressor_chk
  import bdz_pkg::*;
(
  input logic                 clk,
  input logic                 rstN,
  input logic                 inValid,
  input logic [LINE_BITS-1:0] inLine,
  input logic                 outValid,
  input logic                 outCompressed,
  input logic [TAG_W-1:0]     outTag,
  input logic [SIZE_W-1:0]    outSize,
  input logic [LINE_BITS-1:0] outPayload,
  input logic [MASK_W-1:0]    outMask
);
  logic [1:0] sinceRst;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              sinceRst <= '0;
    else if (sinceRst != 2) sinceRst <= sinceRst + 2'd1;
  end

  p_latency_r1: assert property (@(posedge clk) disable iff (!rstN)
    (sinceRst == 2) |-> (outValid == $past(inValid, 2)));

  p_hold_r1: assert property (@(posedge clk) disable iff (!rstN)
    (sinceRst == 2 && !$past(inValid, 2)) |-> ($stable(outPayload) && $stable(outTag)));

  p_zero_r2: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outTag == 0) |-> (outPayload == '0 && outSize == SIZE_W'(ZERO_COST)));

  p_rep_r3: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outTag == 1) |-> (outPayload[LINE_BITS-1:REP_BYTES*8] == '0));

  p_mask_r5: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && (outTag <= 1 || outTag == TAG_W'(TAG_RAW))) |-> (outMask == '0));

  p_size_bound_r6: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outCompressed) |-> (outSize < SIZE_W'(LINE_BYTES)));

  p_raw_r8: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outCompressed) |-> (outTag == TAG_W'(TAG_RAW) && outSize == SIZE_W'(LINE_BYTES)));

  p_flag_r8: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> (outCompressed == (outTag != TAG_W'(TAG_RAW))));

  always_comb begin
    if (!rstN) begin
      a_reset_r9: assert (!outValid);
    end
  end
endmodule

bind bdz_compressor bdz_compressor_chk u_chk (.*);

// File: tb/sim_bdz_compressor.sv
`timescale 1ns/1ps
module sim_bdz_compressor;
  import bdz_pkg::*;

  logic                 clk = 1'b0;
  logic                 rstN = 1'b0;
  logic                 inValid = 1'b0;
  logic [LINE_BITS-1:0] inLine = '0;
  logic                 outValid;
  logic                 outCompressed;
  logic [TAG_W-1:0]     outTag;
  logic [SIZE_W-1:0]    outSize;
  logic [LINE_BITS-1:0] outPayload;
  logic [MASK_W-1:0]    outMask;

  bdz_compressor u0 (.*);

  always #4 clk = ~clk;

  typedef struct {
    int             tag;
    int             size;
    logic [255:0]   pl;
    logic [15:0]    mk;
    int             handTag;
    int             stamp;
    string          req;
  } item_t;

  item_t        sbq[$];
  int           cyc = 0;
  int           total = 0;
  int           bad = 0;
  bit           havePrev = 0;
  logic [255:0] prevPl;
  int           prevTag;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit cond, input string req, input logic [255:0] act, input logic [255:0] exp);
    total++;
    if (!cond) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] sx(input logic [63:0] v, input int dw, input logic [63:0] wm);
    logic [63:0] dm;
    logic [63:0] lo;
    dm = (dw == 8) ? '1 : ((64'd1 << (dw*8)) - 64'd1);
    lo = v & dm;
    if (((lo >> (dw*8 - 1)) & 64'd1) != 0) return (lo | ~dm) & wm;
    return lo;
  endfunction

  task automatic tryBD(input logic [255:0] l, input int bw, input int dw,
                       output bit ok, output logic [255:0] pl, output logic [15:0] mk);
    logic [63:0]  wm;
    logic [63:0]  dm;
    logic [63:0]  base;
    logic [63:0]  e;
    logic [63:0]  d;
    logic [255:0] sh;
    wm   = (bw == 8) ? '1 : ((64'd1 << (bw*8)) - 64'd1);
    dm   = (64'd1 << (dw*8)) - 64'd1;
    base = l[63:0] & wm;
    ok   = 1;
    mk   = '0;
    pl   = {192'd0, base};
    for (int i = 0; i < 32 / bw; i++) begin
      sh = l >> (i*bw*8);
      e  = sh[63:0] & wm;
      d  = (e - base) & wm;
      if (sx(d, dw, wm) == d)      pl = pl | ({192'd0, d & dm} << ((bw + i*dw)*8));
      else if (sx(e, dw, wm) == e) begin
        pl = pl | ({192'd0, e & dm} << ((bw + i*dw)*8));
        mk[i] = 1'b1;
      end else ok = 0;
    end
  endtask

  task automatic refEnc(input logic [255:0] l, output int tag, output int size,
                        output logic [255:0] pl, output logic [15:0] mk);
    int           bws [6] = '{8, 8, 8, 4, 4, 2};
    int           dws [6] = '{1, 2, 4, 1, 2, 1};
    bit           ok;
    logic [255:0] p2;
    logic [15:0]  m2;
    int           sz;
    tag = 8; size = 32; pl = l; mk = '0;
    if (l == '0) begin
      tag = 0; size = 1; pl = '0;
      return;
    end
    if (l == {4{l[63:0]}}) begin
      tag = 1; size = 8; pl = {192'd0, l[63:0]};
    end
    for (int k = 0; k < 6; k++) begin
      tryBD(l, bws[k], dws[k], ok, p2, m2);
      sz = bws[k] + (32 / bws[k]) * dws[k];
      if (ok && sz < size) begin
        tag = k + 2; size = sz; pl = p2; mk = m2;
      end
    end
  endtask

  task automatic send(input logic [255:0] l, input int handTag, input string req);
    item_t it;
    @(negedge clk);
    inValid = 1'b1;
    inLine  = l;
    refEnc(l, it.tag, it.size, it.pl, it.mk);
    it.handTag = handTag;
    it.stamp   = cyc;
    it.req     = req;
    sbq.push_back(it);
  endtask

  task automatic idle(input int n);
    repeat (n) begin
      @(negedge clk);
      inValid = 1'b0;
    end
  endtask

  always @(negedge clk) begin
    if (rstN && outValid) begin
      if (sbq.size() == 0) begin
        check(0, "R1 unexpected result", {255'd0, outValid}, 256'd0);
      end else begin
        item_t it;
        it = sbq.pop_front();
        check(cyc == it.stamp + 2, "R1 R10 latency/order", 256'(cyc - it.stamp), 256'd2);
        if (it.handTag >= 0)
          check(int'(outTag) == it.handTag, {it.req, " R7 tag"}, 256'(outTag), 256'(it.handTag));
        check(int'(outTag) == it.tag, "R4 R7 tag vs model", 256'(outTag), 256'(it.tag));
        check(int'(outSize) == it.size, "R6 size", 256'(outSize), 256'(it.size));
        check(outPayload == it.pl, "R11 R3 R8 payload", outPayload, it.pl);
        check(outMask == it.mk, "R5 mask", 256'(outMask), 256'(it.mk));
        check(outCompressed == (it.tag != 8), "R8 flag", 256'(outCompressed), 256'(it.tag != 8));
        havePrev = 1;
        prevPl   = outPayload;
        prevTag  = int'(outTag);
      end
    end else if (rstN && havePrev) begin
      check(outPayload == prevPl && int'(outTag) == prevTag, "R1 hold", outPayload, prevPl);
    end
  end

  initial begin
    int wd = 0;
    while (wd < 20000) begin
      @(posedge clk);
      wd++;
    end
    check(0, "watchdog", 256'd0, 256'd1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  function automatic logic [255:0] mk8(input logic [63:0] a, b, c, d);
    return {d, c, b, a};
  endfunction

  initial begin
    logic [255:0] l;
    repeat (3) @(negedge clk);
    check(!outValid && !outCompressed && outTag == 0 && outSize == 0 && outPayload == 0 && outMask == 0,
          "R9 reset state", outPayload, 256'd0);
    rstN = 1'b1;
    idle(2);
    check(!outValid && outPayload == 0, "R9 after reset", {255'd0, outValid}, 256'd0);

    send('0, 0, "R2 zero");                                   idle(3);
    send({4{64'h1122334455667788}}, 1, "R3 repeat");          idle(3);
    for (int i = 0; i < 8; i++) l[i*32 +: 32] = 32'hC04039C0 + 32'(i*8);
    send(l, 5, "R4 4/1 pointers");                            idle(3);
    send(mk8(64'd5, 64'd6, 64'd7, 64'd8), 2, "R7 tie 8/1 over 4/1"); idle(3);
    send(mk8(64'h7777000000000000, 64'd3, 64'h7777000000000002, 64'hFFFFFFFFFFFFFFFE),
         2, "R5 zero base mask");                             idle(3);
    send(mk8(64'h123456789ABC0000, 64'h123456789ABC0100, 64'h123456789ABC7FFF,
             64'h123456789ABB8000), 3, "R4 8/2 limits");      idle(2);
    send(mk8(64'h123456789ABC0000, 64'h123456789ABC8000, 64'h123456789ABC0001,
             64'h123456789ABC0002), 4, "R4 8/2 overflow");    idle(2);
    for (int i = 0; i < 8; i++) l[i*32 +: 32] = 32'h40000000 + 32'(i*256);
    send(l, 6, "R4 4/2");                                     idle(2);
    for (int i = 0; i < 16; i++) l[i*16 +: 16] = 16'h1000 + 16'(i);
    send(l, 7, "R4 2/1");                                     idle(2);
    send(mk8(64'h0123456789ABCDEF, 64'hFEDCBA9876543210, 64'h0F1E2D3C4B5A6978,
             64'h8796A5B4C3D2E1F0), 8, "R8 raw");             idle(3);

    for (int r = 0; r < 40; r++) begin
      logic [63:0] b;
      b = {$urandom, $urandom};
      case (r % 4)
        0: l = {$urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom};
        1: l = mk8(b, b + 64'($urandom % 200), 64'($urandom % 100), b - 64'($urandom % 30000));
        2: for (int i = 0; i < 8; i++) l[i*32 +: 32] = b[31:0] + 32'($urandom % 60000) - 32'd30000;
        default: for (int i = 0; i < 16; i++) l[i*16 +: 16] = (i % 3 == 0) ? 16'($urandom % 100) : b[15:0] + 16'(i);
      endcase
      send(l, -1, "R10 burst");
    end
    send('0, 0, "R10 burst zero");
    send({4{64'hA5A5A5A5A5A5A5A5}}, 1, "R10 burst repeat");
    idle(6);
    check(sbq.size() == 0, "R10 drained", 256'(sbq.size()), 256'd0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule